// File: doc/BRIEF.md
# Six-Register I2C Block-Transfer Target

This block is an I2C target holding six 8-bit control registers, whose contents are always visible on a wide parallel output. The host reaches them with fixed block framing rather than a register pointer. A write names the device, then sends two filler bytes (a command byte and a length byte) that are acknowledged but thrown away, then sends data that fills the registers from index 0 upward. A read names the device, receives a length byte first and then the register contents from index 0 upward.

The SCL and SDA inputs are synchronized to the system clock, and START and STOP are recovered from them. SDA is returned as an open-drain enable: when the enable is high, the pad pulls the line low. The block targets standard-mode bus rates, which leaves many system clocks in every SCL phase. The reset contents of the registers are set by a parameter.

Top module: `i2c_blkreg`

## Requirements
- R1: After reset, `regs_o` holds `REG_INIT`, with register k at bits [8k+7:8k], and `sda_oe` is low.
- R2: The target acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged, and the target stays silent and leaves every register unchanged until the next START.
- R3: In a write, the two bytes that follow the address are each acknowledged, and their values reach no register.
- R4: In a write, the data bytes that follow land in registers 0, 1, 2, … in that order, MSB first on the wire. Each one is acknowledged.
- R5: A write data byte beyond the sixth is not acknowledged and is not stored.
- R6: A STOP after any complete byte ends the write. Registers already received keep their new values, and the others keep their old ones.
- R7: In a read, the target sends the value 6 first, then registers 0 to 5 in order, MSB first. Each next byte is sent only after the controller acknowledges the previous one.
- R8: If the controller does not acknowledge a byte during a read, the target releases SDA and drives nothing more until a new START.
- R9: `sda_oe` changes only while the synchronized SCL is low, except for the release forced by a START or STOP.
- R10: A START, including a repeated START, restarts the address phase from any state. A STOP returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line, sampled |
| sda_i | input | 1 | I2C data line, sampled |
| sda_oe | output | 1 | High pulls SDA low |
| regs_o | output | 8*NREG | Register contents, register k at [8k+7:8k] |

## Verification
Two actions share the acknowledge window. A register write commits on the SCL fall that closes a data byte, and a START or STOP from the controller can follow immediately after that acknowledge. The bench provokes this in two ways. It issues a STOP straight after a partial write's acknowledge, and it issues a repeated START with a read address right after one data byte. It then judges the result by whether the committed byte reads back first while the untouched registers keep their earlier values.

// File: rtl/i2c_blkreg_pkg.sv
package i2c_blkreg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } i2c_st_e;
endpackage

// File: rtl/i2c_blkreg_sync.sv
module i2c_blkreg_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC_STAGES-1:0] scl_m, sda_m;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= '1;
      sda_m <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_m <= {scl_m[SYNC_STAGES-2:0], scl_i};
      sda_m <= {sda_m[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_m[SYNC_STAGES-1];
      sda_d <= sda_m[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_m[SYNC_STAGES-1];
  assign sda_s    = sda_m[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_blkreg_bank.sv
module i2c_blkreg_bank #(
  parameter int               NREG     = 6,
  parameter logic [NREG*8-1:0] REG_INIT = '0,
  localparam int              ADR_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADR_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [ADR_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic we;
    assign we = wr_en && (wr_idx == ADR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem[g] <= REG_INIT[8*g +: 8];
      else if (we) mem[g] <= wr_data;
    end
    assign regs_o[8*g +: 8] = mem[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == ADR_W'(i)) rd_data = mem[i];
  end

  // R5: the protocol engine never asks for a register past the last one
  assert_wr_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));
endmodule

// File: rtl/i2c_blkreg_fsm.sv
module i2c_blkreg_fsm
  import i2c_blkreg_pkg::*;
#(
  parameter int         NREG     = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        ADR_W    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int        IDX_W    = $clog2(NREG + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic [7:0]       rd_data,
  output logic [ADR_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [ADR_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG + 2);
  localparam logic [IDX_W-1:0] RD_LAST  = IDX_W'(NREG);
  localparam logic [7:0]       CNT_BYTE = 8'(NREG);

  i2c_st_e          st_q, st_d;
  logic [2:0]       bcnt_q, bcnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d, tx_sel;
  logic             got_q, got_d, rd_q, rd_d, aph_q, aph_d, mok_q, mok_d;
  logic             oe_d, oe_q;
  logic [7:0]       tx_byte;

  always_comb begin
    st_d = st_q;  bcnt_d = bcnt_q; sh_d = sh_q;   idx_d = idx_q;
    got_d = got_q; rd_d = rd_q;    aph_d = aph_q; mok_d = mok_q;
    wr_en   = 1'b0;
    wr_data = sh_q;
    wr_idx  = ADR_W'(idx_q - IDX_W'(2));
    tx_sel  = (st_q == ST_ACK) ? idx_q : idx_q + IDX_W'(1);
    rd_idx  = ADR_W'(tx_sel - IDX_W'(1));
    tx_byte = (tx_sel == '0) ? CNT_BYTE : rd_data;
    if (start_p) begin
      st_d = ST_RX; aph_d = 1'b1; bcnt_d = '0; got_d = 1'b0;
      idx_d = '0;   rd_d = 1'b0;
    end else if (stop_p) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && !got_q) begin
            sh_d   = {sh_q[6:0], sda_s};
            bcnt_d = bcnt_q + 3'd1;
            if (bcnt_q == 3'd7) got_d = 1'b1;
          end else if (scl_fall && got_q) begin
            got_d = 1'b0; bcnt_d = '0;
            if (aph_q) begin
              aph_d = 1'b0; idx_d = '0;
              if (sh_q[7:1] == DEV_ADDR) begin
                rd_d = sh_q[0]; st_d = ST_ACK;
              end else begin
                st_d = ST_IDLE;
              end
            end else if (idx_q < LAST_IDX) begin
              st_d  = ST_ACK;
              idx_d = idx_q + IDX_W'(1);
              if (idx_q >= IDX_W'(2)) wr_en = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              st_d = ST_TX; sh_d = tx_byte; bcnt_d = '0;
            end else begin
              st_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt_q == 3'd7) st_d = ST_MACK;
            else begin
              sh_d   = {sh_q[6:0], 1'b0};
              bcnt_d = bcnt_q + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mok_d = !sda_s;
          if (scl_fall) begin
            idx_d = idx_q + IDX_W'(1);
            if (mok_q && idx_q < RD_LAST) begin
              st_d = ST_TX; sh_d = tx_byte; bcnt_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
    oe_d = (st_d == ST_ACK) || (st_d == ST_TX && !sh_d[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bcnt_q <= '0; sh_q <= '0; idx_q <= '0;
      got_q <= 1'b0; rd_q <= 1'b0; aph_q <= 1'b0; mok_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      st_q <= st_d; bcnt_q <= bcnt_d; sh_q <= sh_d; idx_q <= idx_d;
      got_q <= got_d; rd_q <= rd_d; aph_q <= aph_d; mok_q <= mok_d;
      oe_q <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // R10: any START reopens the address phase
  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st_q == ST_RX) && aph_q);
  // R10: a STOP parks the engine in idle
  assert_stop_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p && !start_p) |=> (st_q == ST_IDLE));
  // R7: transmission happens only in a read transfer
  assert_tx_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX) |-> rd_q);
  // R8: idle never drives the line
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_IDLE && st_q == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2c_blkreg.sv
module i2c_blkreg #(
  parameter int               NREG     = 6,
  parameter logic [6:0]       DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] REG_INIT = 48'h0F1E_2D3C_4B5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int ADR_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [1:0]       rst_ff;
  logic             rst_n_s;
  logic             scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic             wr_en;
  logic [ADR_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_s = rst_ff[1];

  i2c_blkreg_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_blkreg_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  i2c_blkreg_bank #(.NREG(NREG), .REG_INIT(REG_INIT)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o)
  );

  // R9: the data line moves only while the clock line is low
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!$stable(sda_oe) && !$past(start_p || stop_p)) |-> !scl_s);
endmodule

// File: tb/tb_i2c_blkreg.sv
module tb_i2c_blkreg;
  localparam int          NREG = 6;
  localparam logic [47:0] INIT = 48'h0F1E_2D3C_4B5A;
  localparam int          Q    = 10;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  logic [47:0] regs_o;
  wire  sda_line = !(m_low || sda_oe);

  int checks = 0, errors = 0, viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  logic [7:0] exp_r [NREG];

  always #2 clk = ~clk;

  i2c_blkreg dut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
                  .sda_oe(sda_oe), .regs_o(regs_o));

  // R9 monitor: enable must stay still across an SCL high phase
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_oe != prev_oe) viol++;
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    logic [47:0] e;
    for (int k = 0; k < NREG; k++) e[8*k +: 8] = exp_r[k];
    check(regs_o == e, tag, regs_o, e);
  endtask

  task automatic bus_start();
    m_low = 1'b0; hold(Q); m_scl = 1'b1; hold(Q);
    m_low = 1'b1; hold(Q); m_scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hold(Q); m_scl = 1'b1; hold(Q);
    m_low = 1'b0; hold(Q);
  endtask

  task automatic put_bit(input bit b);
    m_low = !b; hold(Q); m_scl = 1'b1; hold(2*Q); m_scl = 1'b0; hold(1);
  endtask

  task automatic get_bit(output bit b);
    m_low = 1'b0; hold(Q); m_scl = 1'b1; hold(Q);
    b = sda_line; hold(Q); m_scl = 1'b0; hold(1);
  endtask

  task automatic put_byte(input logic [7:0] d, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    acked = !a;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!ack);
  endtask

  task automatic t_write_full();
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(8'hD2, a); check(a, "R2 write address ack", 48'(a), 1);
    put_byte(8'h03, a); check(a, "R3 command byte ack", 48'(a), 1);
    put_byte(8'h06, a); check(a, "R3 count byte ack", 48'(a), 1);
    for (int k = 0; k < NREG; k++) begin
      v = 8'hA0 + 8'(k * 17);
      put_byte(v, a); check(a, "R4 data byte ack", 48'(a), 1);
      exp_r[k] = v;
    end
    bus_stop(); hold(Q);
    check_regs("R4 R3 registers after full write");
  endtask

  task automatic t_overflow();
    bit a;
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h00, a);
    for (int k = 0; k < NREG; k++) begin
      put_byte(8'h11 * 8'(k + 1), a);
      exp_r[k] = 8'h11 * 8'(k + 1);
    end
    put_byte(8'hEE, a); check(!a, "R5 seventh data byte nack", 48'(a), 0);
    bus_stop(); hold(Q);
    check_regs("R5 registers after overflow");
  endtask

  task automatic t_partial();
    bit a;
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h7F, a); put_byte(8'h02, a);
    put_byte(8'h3A, a); exp_r[0] = 8'h3A;
    put_byte(8'h5C, a); exp_r[1] = 8'h5C;
    bus_stop(); hold(Q);
    check_regs("R6 early stop keeps rest");
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD3, a); check(a, "R2 read address ack", 48'(a), 1);
    get_byte(d, 1'b1); check(d == 8'd6, "R7 count prefix", 48'(d), 6);
    for (int k = 0; k < NREG; k++) begin
      get_byte(d, k != NREG - 1);
      check(d == exp_r[k], "R7 register readback", 48'(d), 48'(exp_r[k]));
    end
    bus_stop(); hold(Q);
  endtask

  task automatic t_nack();
    bit a;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD3, a); get_byte(d, 1'b1);
    get_byte(d, 1'b0);
    check(d == exp_r[0], "R8 byte before nack", 48'(d), 48'(exp_r[0]));
    for (int i = 7; i >= 0; i--) begin bit b; get_bit(b); d[i] = b; end
    check(d == 8'hFF, "R8 line released after nack", 48'(d), 48'hFF);
    bus_stop(); hold(Q);
  endtask

  task automatic t_bad_addr();
    bit a;
    bus_start();
    put_byte(8'hA0, a); check(!a, "R2 foreign address nack", 48'(a), 0);
    put_byte(8'h00, a); check(!a, "R2 silent after foreign address", 48'(a), 0);
    put_byte(8'h99, a);
    bus_stop(); hold(Q);
    check_regs("R2 registers untouched");
  endtask

  task automatic t_restart();
    bit a;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h01, a); put_byte(8'h01, a);
    put_byte(8'hC3, a); exp_r[0] = 8'hC3;
    bus_start();
    put_byte(8'hD3, a); check(a, "R10 repeated start address ack", 48'(a), 1);
    get_byte(d, 1'b1); check(d == 8'd6, "R10 count after restart", 48'(d), 6);
    get_byte(d, 1'b0); check(d == 8'hC3, "R10 committed byte", 48'(d), 48'hC3);
    bus_stop(); hold(Q);
    check_regs("R10 registers after restart");
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) exp_r[k] = INIT[8*k +: 8];
    hold(5); rst_n = 1'b1; hold(5);
    check_regs("R1 reset defaults");
    check(sda_oe == 1'b0, "R1 line released at reset", 48'(sda_oe), 0);
    t_write_full();
    t_read();
    t_overflow();
    t_partial();
    t_read();
    t_nack();
    t_bad_addr();
    t_restart();
    check(viol == 0, "R9 enable moved during SCL high", 48'(viol), 0);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule